// File: doc/BRIEF.md
# Serial Port Clock and Frame-Sync Generator

This block produces the timing for a synchronous serial port from the system clock. Each side of the port has its own timing channel. In a channel, the system clock first passes a fixed prescaler that divides by 1 or by 8, then a programmable prescaler. Together they set the half period of the bit clock. The bit clock is then counted into words of a selectable length. The words are counted into frames of a programmable size. A frame-sync output is high for the first bit of every frame. A one-cycle strobe marks the first system-clock cycle of each new word. A per-word slot mask decides which words carry data. The mask drives the data-drive enable, which tells the shift register when to drive its pin and when to leave it high impedance.

The channel has two clock modes. In continuous mode the bit clock runs all the time and the frame sync marks each frame. In gated mode the bit clock toggles only during words whose mask bit is set, so the clock itself shows where the data is, and the frame sync stays low. When the shared-clock mode is selected, the receive outputs copy the transmit channel and the receive settings are ignored. When it is not selected, the receive side runs from its own settings. The shared-clock selection is taken while the enable is low. The divider and slot settings are taken at each frame boundary, so a change never cuts a frame short. Every output is a system-clock-domain register. The bit clock is therefore delivered as a registered level.

Top module: `spclk_gen`

## Requirements
- R1: While rst is high, and on the first clock edge after en is sampled low, every output is 0. Raising en restarts all counters. The first frame begins with bit 0 of word 0, with the bit clock low.
- R2: The bit clock stays high for T system cycles and low for T system cycles. T = F*(PM+1), where F is 1 when the fixed-prescaler select is 0 and 8 when it is 1, and PM is the programmable prescaler value.
- R3: The word-length code sets the bits per word: code 0 gives 8, code 1 gives 12, code 2 gives 16 and code 3 gives 24. There is one bit-clock rising edge per bit.
- R4: A frame holds DC+1 words, where DC is the frame-size field. In continuous mode the frame sync rises once per frame, every 2*T*bits*(DC+1) system cycles, and stays high for the first bit of the frame.
- R5: The word strobe (tx_empty for transmit, rx_full for receive) is a one-cycle pulse in the first cycle of every word, DC+1 pulses per frame. The bit clock is low in that cycle.
- R6: In gated mode (gated input 1) the bit clock toggles only in words whose slot-mask bit is 1, and the frame sync stays 0.
- R7: The drive enable (tx_oe, and rx_act for receive) is high exactly during word n of a frame when bit n of the slot mask is 1. Mask bit 0 belongs to word 0.
- R8: With sync_mode = 1 (sampled while en is low), all four receive outputs equal the transmit outputs in every cycle, whatever the receive settings are.
- R9: With sync_mode = 0, the receive outputs follow the receive settings, independently of the transmit settings.
- R10: A change to a channel's settings while it runs takes effect at the next frame boundary. The frame in progress keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Synchronous run enable; low clears all counters |
| sync_mode | input | 1 | 1 = receive shares the transmit timing; sampled while en is low |
| tx_fix8 | input | 1 | Transmit fixed prescaler: 0 divides by 1, 1 divides by 8 |
| tx_pm | input | PM_W | Transmit programmable prescaler value (divides by value+1) |
| tx_wlen | input | 2 | Transmit word-length code (8/12/16/24 bits) |
| tx_frm | input | DC_W | Transmit frame size minus one, in words |
| tx_gated | input | 1 | Transmit gated-clock mode |
| tx_mask | input | NW | Transmit slot mask, bit n for word n |
| rx_fix8 | input | 1 | Receive fixed prescaler select |
| rx_pm | input | PM_W | Receive programmable prescaler value |
| rx_wlen | input | 2 | Receive word-length code |
| rx_frm | input | DC_W | Receive frame size minus one |
| rx_gated | input | 1 | Receive gated-clock mode |
| rx_mask | input | NW | Receive slot mask |
| tx_sck | output | 1 | Transmit bit clock |
| tx_fs | output | 1 | Transmit frame sync |
| tx_empty | output | 1 | Transmit word-boundary strobe |
| tx_oe | output | 1 | Transmit data drive enable |
| rx_sck | output | 1 | Receive bit clock |
| rx_fs | output | 1 | Receive frame sync |
| rx_full | output | 1 | Receive word-boundary strobe |
| rx_act | output | 1 | Receive slot-active window |

## Verification
The assertions check, on every cycle, the rules that depend only on the current and previous cycle: outputs clear after en is low, the word strobe lasts a single cycle, and the frame sync and word strobe start while the bit clock is low. They also check that in gated mode the clock is never high outside an enabled slot and the frame sync never rises. Counted quantities need whole scenarios in the bench. These are the half period for each prescaler setting, the edges per word for each length code, the frame period, the drive-enable time for a given mask, and the receive side copying the transmit side in shared mode. The bench scenarios also cover the two sides running at different rates, and a setting changed mid-frame that takes effect only at the next frame.

// File: rtl/spclk_pkg.sv
package spclk_pkg;

  localparam int BIT_W   = 5;
  localparam int FIX_DIV = 8;
  localparam int FIX_W   = $clog2(FIX_DIV);

  typedef enum logic [1:0] {
    WL_8  = 2'd0,
    WL_12 = 2'd1,
    WL_16 = 2'd2,
    WL_24 = 2'd3
  } wlen_e;

  // index of the last bit in a word for a length code
  function automatic logic [BIT_W-1:0] wlen_last(input logic [1:0] code);
    logic [BIT_W-1:0] r;
    case (wlen_e'(code))
      WL_8:    r = BIT_W'(7);
      WL_12:   r = BIT_W'(11);
      WL_16:   r = BIT_W'(15);
      default: r = BIT_W'(23);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/spclk_presc.sv
module spclk_presc
  import spclk_pkg::*;
#(
  parameter int PM_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            fix8,
  input  logic [PM_W-1:0] pm,
  output logic            tick
);

  logic [FIX_W-1:0] fc_q;
  logic [PM_W-1:0]  pc_q;
  logic             fix_tick;

  // stage 1: fixed divide by 1 or 8
  assign fix_tick = !fix8 || (fc_q == FIX_W'(FIX_DIV - 1));
  // stage 2: programmable divide by pm+1
  assign tick     = run && fix_tick && (pc_q == pm);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      fc_q <= '0;
      pc_q <= '0;
    end else begin
      fc_q <= fix8 ? fc_q + 1'b1 : '0;
      if (fix_tick) begin
        pc_q <= (pc_q == pm) ? '0 : pc_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spclk_seq.sv
module spclk_seq
  import spclk_pkg::*;
#(
  parameter int DC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [1:0]       wlen,
  input  logic [DC_W-1:0]  last_word,
  output logic             live_n,
  output logic             ph_n,
  output logic [BIT_W-1:0] bit_n,
  output logic [DC_W-1:0]  word_n,
  output logic             word_end,
  output logic             frame_end
);

  logic             live_q;
  logic             ph_q;
  logic [BIT_W-1:0] bit_q;
  logic [DC_W-1:0]  word_q;
  logic [BIT_W-1:0] last_bit;

  assign last_bit = wlen_last(wlen);

  always_comb begin
    live_n    = live_q | tick;
    ph_n      = ph_q;
    bit_n     = bit_q;
    word_n    = word_q;
    word_end  = 1'b0;
    frame_end = 1'b0;
    if (tick && live_q) begin
      ph_n = !ph_q;
      if (ph_q) begin
        if (bit_q == last_bit) begin
          bit_n    = '0;
          word_end = 1'b1;
          if (word_q == last_word) begin
            word_n    = '0;
            frame_end = 1'b1;
          end else begin
            word_n = word_q + 1'b1;
          end
        end else begin
          bit_n = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      live_q <= 1'b0;
      ph_q   <= 1'b0;
      bit_q  <= '0;
      word_q <= '0;
    end else begin
      live_q <= live_n;
      ph_q   <= ph_n;
      bit_q  <= bit_n;
      word_q <= word_n;
    end
  end

endmodule

// File: rtl/spclk_chan.sv
module spclk_chan
  import spclk_pkg::*;
#(
  parameter int PM_W = 8,
  parameter int DC_W = 5,
  parameter int NW   = 1 << DC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            c_fix8,
  input  logic [PM_W-1:0] c_pm,
  input  logic [1:0]      c_wlen,
  input  logic [DC_W-1:0] c_last,
  input  logic            c_gated,
  input  logic [NW-1:0]   c_mask,
  output logic            sck,
  output logic            fs,
  output logic            wstb,
  output logic            act,
  output logic            gated_o
);

  // settings in force for the current frame
  logic            fix8_q,  fix8_n;
  logic [PM_W-1:0] pm_q,    pm_n;
  logic [1:0]      wlen_q,  wlen_n;
  logic [DC_W-1:0] last_q,  last_n;
  logic            gated_q, gated_n;
  logic [NW-1:0]   mask_q,  mask_n;

  logic             tick;
  logic             live_n, ph_n, word_end, frame_end, load, slot_n;
  logic [BIT_W-1:0] bit_n;
  logic [DC_W-1:0]  word_n;

  assign load    = !run || frame_end;
  assign fix8_n  = load ? c_fix8  : fix8_q;
  assign pm_n    = load ? c_pm    : pm_q;
  assign wlen_n  = load ? c_wlen  : wlen_q;
  assign last_n  = load ? c_last  : last_q;
  assign gated_n = load ? c_gated : gated_q;
  assign mask_n  = load ? c_mask  : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fix8_q  <= 1'b0;
      pm_q    <= '0;
      wlen_q  <= '0;
      last_q  <= '0;
      gated_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      fix8_q  <= fix8_n;
      pm_q    <= pm_n;
      wlen_q  <= wlen_n;
      last_q  <= last_n;
      gated_q <= gated_n;
      mask_q  <= mask_n;
    end
  end

  spclk_presc #(.PM_W(PM_W)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .fix8 (fix8_q),
    .pm   (pm_q),
    .tick (tick)
  );

  spclk_seq #(.DC_W(DC_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .tick      (tick),
    .wlen      (wlen_q),
    .last_word (last_q),
    .live_n    (live_n),
    .ph_n      (ph_n),
    .bit_n     (bit_n),
    .word_n    (word_n),
    .word_end  (word_end),
    .frame_end (frame_end)
  );

  assign slot_n = mask_n[word_n];

  // registered outputs, aligned with the sequencer state
  always_ff @(posedge clk) begin
    if (rst || !run || !live_n) begin
      sck  <= 1'b0;
      fs   <= 1'b0;
      wstb <= 1'b0;
      act  <= 1'b0;
    end else begin
      sck  <= ph_n && (!gated_n || slot_n);
      fs   <= !gated_n && (word_n == '0) && (bit_n == '0);
      wstb <= word_end;
      act  <= slot_n;
    end
  end

  assign gated_o = gated_q;

endmodule

// File: rtl/spclk_gen.sv
module spclk_gen
  import spclk_pkg::*;
#(
  parameter int PM_W = 8,
  parameter int DC_W = 5,
  parameter int NW   = 1 << DC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            sync_mode,
  input  logic            tx_fix8,
  input  logic [PM_W-1:0] tx_pm,
  input  logic [1:0]      tx_wlen,
  input  logic [DC_W-1:0] tx_frm,
  input  logic            tx_gated,
  input  logic [NW-1:0]   tx_mask,
  input  logic            rx_fix8,
  input  logic [PM_W-1:0] rx_pm,
  input  logic [1:0]      rx_wlen,
  input  logic [DC_W-1:0] rx_frm,
  input  logic            rx_gated,
  input  logic [NW-1:0]   rx_mask,
  output logic            tx_sck,
  output logic            tx_fs,
  output logic            tx_empty,
  output logic            tx_oe,
  output logic            rx_sck,
  output logic            rx_fs,
  output logic            rx_full,
  output logic            rx_act
);

  localparam int NCH = 2;
  localparam int TXC = 0;
  localparam int RXC = 1;

  logic mode_q;

  always_ff @(posedge clk) begin
    if (rst)      mode_q <= 1'b1;
    else if (!en) mode_q <= sync_mode;
  end

  logic            c_fix8  [NCH];
  logic [PM_W-1:0] c_pm    [NCH];
  logic [1:0]      c_wlen  [NCH];
  logic [DC_W-1:0] c_last  [NCH];
  logic            c_gated [NCH];
  logic [NW-1:0]   c_mask  [NCH];
  logic            c_run   [NCH];
  logic            ch_sck  [NCH];
  logic            ch_fs   [NCH];
  logic            ch_wstb [NCH];
  logic            ch_act  [NCH];
  logic            ch_gated[NCH];

  assign c_fix8[TXC]  = tx_fix8;
  assign c_pm[TXC]    = tx_pm;
  assign c_wlen[TXC]  = tx_wlen;
  assign c_last[TXC]  = tx_frm;
  assign c_gated[TXC] = tx_gated;
  assign c_mask[TXC]  = tx_mask;
  assign c_run[TXC]   = en;

  assign c_fix8[RXC]  = rx_fix8;
  assign c_pm[RXC]    = rx_pm;
  assign c_wlen[RXC]  = rx_wlen;
  assign c_last[RXC]  = rx_frm;
  assign c_gated[RXC] = rx_gated;
  assign c_mask[RXC]  = rx_mask;
  assign c_run[RXC]   = en && !mode_q;   // receive channel idles when shared

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    spclk_chan #(.PM_W(PM_W), .DC_W(DC_W), .NW(NW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .run     (c_run[gi]),
      .c_fix8  (c_fix8[gi]),
      .c_pm    (c_pm[gi]),
      .c_wlen  (c_wlen[gi]),
      .c_last  (c_last[gi]),
      .c_gated (c_gated[gi]),
      .c_mask  (c_mask[gi]),
      .sck     (ch_sck[gi]),
      .fs      (ch_fs[gi]),
      .wstb    (ch_wstb[gi]),
      .act     (ch_act[gi]),
      .gated_o (ch_gated[gi])
    );
  end

  assign tx_sck   = ch_sck[TXC];
  assign tx_fs    = ch_fs[TXC];
  assign tx_empty = ch_wstb[TXC];
  assign tx_oe    = ch_act[TXC];

  assign rx_sck   = mode_q ? ch_sck[TXC]  : ch_sck[RXC];
  assign rx_fs    = mode_q ? ch_fs[TXC]   : ch_fs[RXC];
  assign rx_full  = mode_q ? ch_wstb[TXC] : ch_wstb[RXC];
  assign rx_act   = mode_q ? ch_act[TXC]  : ch_act[RXC];

endmodule

// File: rtl/spclk_gen_chk.sv
module spclk_gen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic mode_q,
  input logic g_tx,
  input logic g_rx,
  input logic tx_sck,
  input logic tx_fs,
  input logic tx_empty,
  input logic tx_oe,
  input logic rx_sck,
  input logic rx_fs,
  input logic rx_full,
  input logic rx_act
);

  assert_idle_clear_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!tx_sck && !tx_fs && !tx_empty && !tx_oe &&
             !rx_sck && !rx_fs && !rx_full && !rx_act));

  assert_frame_low_half_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_fs) |-> !tx_sck);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    tx_empty |=> !tx_empty);

  assert_strobe_low_half_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> !tx_sck);

  assert_gated_no_fs_R6: assert property (@(posedge clk) disable iff (rst)
    g_tx |-> !tx_fs);

  assert_gated_clk_in_slot_R7: assert property (@(posedge clk) disable iff (rst)
    (g_tx && tx_sck) |-> tx_oe);

  assert_gated_rx_in_slot_R9: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && g_rx && rx_sck) |-> rx_act);

endmodule

bind spclk_gen spclk_gen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .mode_q   (mode_q),
  .g_tx     (ch_gated[0]),
  .g_rx     (ch_gated[1]),
  .tx_sck   (tx_sck),
  .tx_fs    (tx_fs),
  .tx_empty (tx_empty),
  .tx_oe    (tx_oe),
  .rx_sck   (rx_sck),
  .rx_fs    (rx_fs),
  .rx_full  (rx_full),
  .rx_act   (rx_act)
);

// File: tb/spclk_gen_bench.sv
module spclk_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        sync_mode = 1'b1;
  logic        tx_fix8 = 1'b0, rx_fix8 = 1'b0;
  logic [7:0]  tx_pm = '0, rx_pm = '0;
  logic [1:0]  tx_wlen = '0, rx_wlen = '0;
  logic [4:0]  tx_frm = '0, rx_frm = '0;
  logic        tx_gated = 1'b0, rx_gated = 1'b0;
  logic [31:0] tx_mask = '0, rx_mask = '0;
  logic        tx_sck, tx_fs, tx_empty, tx_oe;
  logic        rx_sck, rx_fs, rx_full, rx_act;

  always #10 clk = ~clk;

  spclk_gen u_spclk_gen (
    .clk(clk), .rst(rst), .en(en), .sync_mode(sync_mode),
    .tx_fix8(tx_fix8), .tx_pm(tx_pm), .tx_wlen(tx_wlen), .tx_frm(tx_frm),
    .tx_gated(tx_gated), .tx_mask(tx_mask),
    .rx_fix8(rx_fix8), .rx_pm(rx_pm), .rx_wlen(rx_wlen), .rx_frm(rx_frm),
    .rx_gated(rx_gated), .rx_mask(rx_mask),
    .tx_sck(tx_sck), .tx_fs(tx_fs), .tx_empty(tx_empty), .tx_oe(tx_oe),
    .rx_sck(rx_sck), .rx_fs(rx_fs), .rx_full(rx_full), .rx_act(rx_act)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  logic p_sck, p_fs;

  always @(posedge clk) cyc++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        fix8;
    logic [7:0]  pm;
    logic [1:0]  wl;
    logic [4:0]  dc;
    logic        gated;
    logic [31:0] mask;
    logic [31:0] period;
    logic [31:0] rises;
    logic [31:0] words;
    logic [31:0] oeh;
    logic [31:0] fsr;
  } vec_t;

  // stimulus and expected counts over one frame
  localparam vec_t VECS [6] = '{
    '{1'b0, 8'd0, 2'd0, 5'd2, 1'b0, 32'h7, 32'd48,   32'd24, 32'd3, 32'd48,   32'd1},
    '{1'b1, 8'd2, 2'd1, 5'd1, 1'b0, 32'h3, 32'd1152, 32'd24, 32'd2, 32'd1152, 32'd1},
    '{1'b0, 8'd4, 2'd2, 5'd0, 1'b0, 32'h1, 32'd160,  32'd16, 32'd1, 32'd160,  32'd1},
    '{1'b1, 8'd0, 2'd3, 5'd3, 1'b0, 32'h5, 32'd1536, 32'd96, 32'd4, 32'd768,  32'd1},
    '{1'b0, 8'd0, 2'd0, 5'd2, 1'b1, 32'h5, 32'd48,   32'd16, 32'd3, 32'd32,   32'd0},
    '{1'b0, 8'd1, 2'd1, 5'd3, 1'b1, 32'h6, 32'd192,  32'd24, 32'd4, 32'd96,   32'd0}
  };

  task automatic align(input int k);
    logic ps, pf;
    int seen = 0;
    ps = tx_sck; pf = tx_fs;
    while (seen < k) begin
      ps = tx_sck; pf = tx_fs;
      @(negedge clk);
      if (tx_empty) seen++;
    end
    p_sck = ps; p_fs = pf;
  endtask

  task automatic window(input int n, output int rises, output int words,
                        output int oeh, output int fsr, output int mism);
    rises = 0; words = 0; oeh = 0; fsr = 0; mism = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (tx_sck && !p_sck) rises++;
      if (tx_fs && !p_fs) fsr++;
      if (tx_empty) words++;
      if (tx_oe) oeh++;
      if (rx_sck != tx_sck || rx_fs != tx_fs || rx_full != tx_empty || rx_act != tx_oe)
        mism++;
      p_sck = tx_sck; p_fs = tx_fs;
    end
  endtask

  task automatic fs_rise(input bit side, output int t);
    logic p, c;
    p = side ? rx_fs : tx_fs;
    forever begin
      @(negedge clk);
      c = side ? rx_fs : tx_fs;
      if (c && !p) break;
      p = c;
    end
    t = cyc;
  endtask

  task automatic high_len(input bit side, output int len);
    logic p;
    p = side ? rx_sck : tx_sck;
    forever begin
      @(negedge clk);
      if ((side ? rx_sck : tx_sck) && !p) break;
      p = side ? rx_sck : tx_sck;
    end
    len = 0;
    while (side ? rx_sck : tx_sck) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic all_zero(input string req);
    chk(req, int'({tx_sck, tx_fs, tx_empty, tx_oe, rx_sck, rx_fs, rx_full, rx_act}), 0);
  endtask

  initial begin
    #(20ns * 150000);
    n_err++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int rises, words, oeh, fsr, mism, t0, t1, t2, hl, tval;
    repeat (4) @(negedge clk);
    all_zero("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    all_zero("R1 disabled");

    foreach (VECS[v]) begin
      en = 1'b0;
      sync_mode = 1'b1;
      tx_fix8 = VECS[v].fix8; tx_pm = VECS[v].pm; tx_wlen = VECS[v].wl;
      tx_frm = VECS[v].dc; tx_gated = VECS[v].gated; tx_mask = VECS[v].mask;
      // receive settings differ and must be ignored in shared mode
      rx_fix8 = 1'b1; rx_pm = 8'd7; rx_wlen = 2'd3; rx_frm = 5'd1;
      rx_gated = ~VECS[v].gated; rx_mask = 32'h0;
      repeat (3) @(negedge clk);
      en = 1'b1;
      align(2);
      window(int'(VECS[v].period), rises, words, oeh, fsr, mism);
      chk(VECS[v].gated ? "R6 clock edges in active slots" : "R3 clock edges per frame",
          rises, int'(VECS[v].rises));
      chk("R5 word strobes per frame", words, int'(VECS[v].words));
      chk("R7 drive-enable cycles per frame", oeh, int'(VECS[v].oeh));
      chk(VECS[v].gated ? "R6 no frame sync in gated mode" : "R4 one frame sync per frame",
          fsr, int'(VECS[v].fsr));
      chk("R8 receive mirrors transmit", mism, 0);
      tval = (VECS[v].fix8 ? 8 : 1) * (int'(VECS[v].pm) + 1);
      high_len(1'b0, hl);
      chk("R2 bit clock high time", hl, tval);
      if (!VECS[v].gated) begin
        fs_rise(1'b0, t0);
        fs_rise(1'b0, t1);
        chk("R4 frame period", t1 - t0, int'(VECS[v].period));
      end
    end

    en = 1'b0;
    @(negedge clk);
    all_zero("R1 enable low clears");

    // separate transmit and receive timing
    sync_mode = 1'b0;
    tx_fix8 = 1'b0; tx_pm = 8'd0; tx_wlen = 2'd0; tx_frm = 5'd2; tx_gated = 1'b0; tx_mask = 32'h7;
    rx_fix8 = 1'b1; rx_pm = 8'd0; rx_wlen = 2'd0; rx_frm = 5'd0; rx_gated = 1'b0; rx_mask = 32'h1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    fs_rise(1'b0, t0);
    fs_rise(1'b0, t1);
    chk("R9 transmit frame period", t1 - t0, 48);
    fs_rise(1'b1, t0);
    fs_rise(1'b1, t1);
    chk("R9 receive frame period", t1 - t0, 128);
    high_len(1'b1, hl);
    chk("R2 receive bit clock high time", hl, 8);

    // setting change mid-frame waits for the frame boundary
    en = 1'b0;
    sync_mode = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    fs_rise(1'b0, t0);
    repeat (5) @(negedge clk);
    tx_frm = 5'd0;
    fs_rise(1'b0, t1);
    fs_rise(1'b0, t2);
    chk("R10 running frame keeps length", t1 - t0, 48);
    chk("R10 new frame size applied", t2 - t1, 16);

    en = 1'b0;
    @(negedge clk);
    all_zero("R1 stop after change");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule